// File: doc/BRIEF.md
# Audio Subframe Sample Formatter

This block sits after a bi-phase line decoder in a digital audio receive path. It accepts one decoded 32-bit subframe at a time and turns it into words ready for memory. In wide mode the 24-bit audio field is masked and left-justified in a 32-bit word, with zeros below it. This covers sample sizes from 17 to 24 bits. In narrow mode only the upper 16 audio bits are kept, and the first-channel and second-channel samples of a frame are packed into one word.

Every subframe is also checked for even parity and for its validity bit, and each fault raises a sticky flag. Software clears a flag by pulsing its clear input. The channel-status bit of every first-channel subframe is gathered over a block. At each block start, the first 32 gathered bits of the block just ended are published. The mode is sampled only on a block-start subframe, so a word is never built from two formats.

Top module: `sfmt_formatter`

## Requirements
- R1: In wide mode, each accepted subframe gives `out_valid` high for exactly the next cycle, with `out_word = {sf_data[27:4] & cfg_mask, 8'h00}`.
- R2: A zero bit in `cfg_mask` forces the matching sample bit to zero. For example, mask 24'hFFFFF0 keeps a 20-bit sample and clears the 4 bits below it.
- R3: In narrow mode, a first-channel subframe (`sf_first`=1) produces no word. The next second-channel subframe gives `out_valid` for one cycle with `out_word = {second[27:12], first[27:12]}`.
- R4: In narrow mode, a second-channel subframe with no first-channel sample waiting produces no word.
- R5: The active mode (`cfg_wide`=1 wide, 0 narrow) is loaded only from a subframe with `sf_block_start`=1, and it already applies to that subframe. Changing `cfg_wide` at any other time has no effect. After reset, wide mode is active.
- R6: A subframe with an odd number of ones in bits 31..4 sets `sts_parity_err`. The flag stays set until it is cleared.
- R7: A `clr_parity` or `clr_invalid` pulse clears its flag on the next edge. If a new fault arrives in the same cycle as the clear, the flag stays set.
- R8: A subframe with bit 28 (validity) equal to 1 sets the sticky flag `sts_invalid`.
- R9: On a block-start subframe, `cs_word` takes the channel-status bits (bit 30) of the first 32 first-channel subframes of the previous block, with frame k at bit k. The block-start subframe's own bit becomes frame 0 of the new block.
- R10: After reset, `out_valid`, both flags and `cs_word` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sf_valid | input | 1 | Subframe strobe |
| sf_data | input | 32 | Decoded subframe; 27..4 audio, 28 validity, 30 channel status, 31 parity |
| sf_first | input | 1 | Subframe belongs to the first channel |
| sf_block_start | input | 1 | Subframe opens a new block |
| cfg_wide | input | 1 | Requested mode: 1 wide, 0 narrow pair packing |
| cfg_mask | input | 24 | Sample bitmask for wide mode |
| clr_parity | input | 1 | Clear pulse for the parity flag |
| clr_invalid | input | 1 | Clear pulse for the validity flag |
| out_valid | output | 1 | Output word strobe |
| out_word | output | 32 | Formatted word |
| sts_parity_err | output | 1 | Sticky parity fault |
| sts_invalid | output | 1 | Sticky sample-not-valid flag |
| cs_word | output | 32 | Published channel-status bits |

## Verification
Random blocks mix wide and narrow mode, varied masks, parity faults, set validity bits and random channel-status bits. This separates correct field slicing and masking from bit-offset mistakes, and it shows whether the flags are truly sticky. Directed cases cover the following:
- a truncating mask, which shows that masking happens before padding;
- a lone second-channel subframe, which separates correct pairing from packing stale data;
- a mid-block mode request, which shows that the mode is sampled only at block start;
- a clear pulse in the same cycle as a new fault, which shows that the set wins.

Blocks longer than 32 frames show whether channel-status capture stops at 32 bits and whether it is published one block late.

// File: rtl/sfmt_pkg.sv
package sfmt_pkg;
   // Fixed subframe bit positions the neighbour decoder delivers
   localparam int unsigned SF_W      = 32;
   localparam int unsigned AUD_LSB   = 4;
   localparam int unsigned VALID_POS = 28;
   localparam int unsigned CSTAT_POS = 30;
   localparam int unsigned PAR_POS   = 31;

   typedef enum logic {
      MODE_NARROW = 1'b0,
      MODE_WIDE   = 1'b1
   } sfmt_mode_e;

   typedef struct packed {
      logic parity_bad;
      logic valid_bad;
      logic cstat;
   } sfmt_flags_t;
endpackage

// File: rtl/sfmt_field_sel.sv
module sfmt_field_sel
   import sfmt_pkg::*;
#(
   parameter int unsigned WORD_W   = 32,
   parameter int unsigned AUD_W    = 24,
   parameter int unsigned NARROW_W = 16,
   parameter bit          MASK_EN  = 1'b1
) (
   input  logic [SF_W-1:0]     sf_data,
   input  logic [AUD_W-1:0]    mask,
   output logic [WORD_W-1:0]   wide_word,
   output logic [NARROW_W-1:0] narrow_smp,
   output sfmt_flags_t         flags
);
   localparam int unsigned AUD_MSB = AUD_LSB + AUD_W - 1;
   localparam int unsigned PAD_W   = WORD_W - AUD_W;
   localparam int unsigned NAR_LSB = AUD_MSB - NARROW_W + 1;

   if (AUD_MSB >= VALID_POS) begin : g_chk_aud
      $error("audio field overlaps the flag bits");
   end
   if (NARROW_W > AUD_W) begin : g_chk_nar
      $error("narrow sample wider than audio field");
   end
   if (WORD_W <= AUD_W) begin : g_chk_word
      $error("word must be wider than audio field");
   end

   logic [AUD_W-1:0] raw_smp;
   logic [AUD_W-1:0] kept_smp;

   assign raw_smp = sf_data[AUD_MSB:AUD_LSB];

   if (MASK_EN) begin : g_mask
      assign kept_smp = raw_smp & mask;
   end else begin : g_nomask
      logic unused_mask;
      assign unused_mask = ^mask;
      assign kept_smp    = raw_smp;
   end

   assign wide_word  = {kept_smp, {PAD_W{1'b0}}};
   assign narrow_smp = sf_data[AUD_MSB:NAR_LSB];

   // even parity spans everything from the audio LSB to the parity bit
   assign flags.parity_bad = ^sf_data[PAR_POS:AUD_LSB];
   assign flags.valid_bad  = sf_data[VALID_POS];
   assign flags.cstat      = sf_data[CSTAT_POS];

   logic unused_bits;
   assign unused_bits = ^{sf_data[AUD_LSB-1:0], sf_data[SF_W-1:AUD_MSB+1]};
endmodule

// File: rtl/sfmt_packer.sv
module sfmt_packer
   import sfmt_pkg::*;
#(
   parameter int unsigned WORD_W   = 32,
   parameter int unsigned NARROW_W = 16,
   parameter bit          RST_WIDE = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                sf_valid,
   input  logic                sf_first,
   input  logic                sf_block_start,
   input  logic                cfg_wide,
   input  logic [WORD_W-1:0]   wide_word,
   input  logic [NARROW_W-1:0] narrow_smp,
   output logic                out_valid,
   output logic [WORD_W-1:0]   out_word,
   output sfmt_mode_e          active_mode,
   output logic                eff_wide,
   output logic                word_wide
);
   localparam int unsigned PAIR_W = 2 * NARROW_W;

   if (PAIR_W > WORD_W) begin : g_chk_pair
      $error("two narrow samples do not fit one word");
   end

   sfmt_mode_e          mode_q;
   logic                pend_q, pend_n;
   logic [NARROW_W-1:0] low_q, low_n;
   logic                ov_n;
   logic [WORD_W-1:0]   ow_n;
   logic [WORD_W-1:0]   pair_word;
   logic                start;

   assign start    = sf_valid && sf_block_start;
   assign eff_wide = start ? cfg_wide : (mode_q == MODE_WIDE);

   if (PAIR_W == WORD_W) begin : g_pair_full
      assign pair_word = {narrow_smp, low_q};
   end else begin : g_pair_pad
      assign pair_word = {{(WORD_W-PAIR_W){1'b0}}, narrow_smp, low_q};
   end

   always_comb begin
      ov_n   = 1'b0;
      ow_n   = out_word;
      pend_n = start ? 1'b0 : pend_q;
      low_n  = low_q;
      if (sf_valid) begin
         if (eff_wide) begin
            ov_n = 1'b1;
            ow_n = wide_word;
         end else if (sf_first) begin
            pend_n = 1'b1;
            low_n  = narrow_smp;
         end else if (pend_n) begin
            ov_n   = 1'b1;
            ow_n   = pair_word;
            pend_n = 1'b0;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q    <= RST_WIDE ? MODE_WIDE : MODE_NARROW;
         pend_q    <= 1'b0;
         low_q     <= '0;
         out_valid <= 1'b0;
         out_word  <= '0;
         word_wide <= RST_WIDE;
      end else begin
         if (start) begin
            mode_q <= cfg_wide ? MODE_WIDE : MODE_NARROW;
         end
         pend_q    <= pend_n;
         low_q     <= low_n;
         out_valid <= ov_n;
         out_word  <= ow_n;
         if (ov_n) begin
            word_wide <= eff_wide;
         end
      end
   end

   assign active_mode = mode_q;
endmodule

// File: rtl/sfmt_status.sv
module sfmt_status
   import sfmt_pkg::*;
#(
   parameter int unsigned FRAMES = 192,
   parameter int unsigned CS_W   = 32
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            sf_valid,
   input  logic            sf_first,
   input  logic            sf_block_start,
   input  sfmt_flags_t     flags,
   input  logic            clr_parity,
   input  logic            clr_invalid,
   output logic            sts_parity_err,
   output logic            sts_invalid,
   output logic [CS_W-1:0] cs_word
);
   localparam int unsigned CNT_W = $clog2(FRAMES + 1);
   localparam int unsigned IDX_W = (CS_W > 1) ? $clog2(CS_W) : 1;

   if (CS_W > FRAMES) begin : g_chk_cs
      $error("published status wider than one block");
   end

   logic [CS_W-1:0]  coll_q, coll_n;
   logic [CNT_W-1:0] cnt_q, cnt_n, cnt_base;
   logic             start;

   assign start = sf_valid && sf_block_start;

   always_comb begin
      coll_n   = start ? '0 : coll_q;
      cnt_base = start ? '0 : cnt_q;
      cnt_n    = cnt_base;
      if (sf_valid && sf_first) begin
         if (cnt_base < CNT_W'(CS_W)) begin
            coll_n[cnt_base[IDX_W-1:0]] = flags.cstat;
         end
         if (cnt_base < CNT_W'(FRAMES)) begin
            cnt_n = cnt_base + CNT_W'(1);
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sts_parity_err <= 1'b0;
         sts_invalid    <= 1'b0;
         coll_q         <= '0;
         cnt_q          <= '0;
         cs_word        <= '0;
      end else begin
         sts_parity_err <= (sts_parity_err & ~clr_parity) | (sf_valid & flags.parity_bad);
         sts_invalid    <= (sts_invalid & ~clr_invalid) | (sf_valid & flags.valid_bad);
         coll_q         <= coll_n;
         cnt_q          <= cnt_n;
         if (start) begin
            cs_word <= coll_q;
         end
      end
   end
endmodule

// File: rtl/sfmt_formatter.sv
module sfmt_formatter
   import sfmt_pkg::*;
#(
   parameter int unsigned WORD_W   = 32,
   parameter int unsigned AUD_W    = 24,
   parameter int unsigned NARROW_W = 16,
   parameter int unsigned FRAMES   = 192,
   parameter int unsigned CS_W     = 32,
   parameter bit          MASK_EN  = 1'b1,
   parameter bit          RST_WIDE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sf_valid,
   input  logic [SF_W-1:0]   sf_data,
   input  logic              sf_first,
   input  logic              sf_block_start,
   input  logic              cfg_wide,
   input  logic [AUD_W-1:0]  cfg_mask,
   input  logic              clr_parity,
   input  logic              clr_invalid,
   output logic              out_valid,
   output logic [WORD_W-1:0] out_word,
   output logic              sts_parity_err,
   output logic              sts_invalid,
   output logic [CS_W-1:0]   cs_word
);
   logic [WORD_W-1:0]   wide_word;
   logic [NARROW_W-1:0] narrow_smp;
   sfmt_flags_t         flags;
   sfmt_mode_e          active_mode;
   logic                eff_wide;
   logic                word_wide;

   sfmt_field_sel #(
      .WORD_W  (WORD_W),
      .AUD_W   (AUD_W),
      .NARROW_W(NARROW_W),
      .MASK_EN (MASK_EN)
   ) u_sel (
      .sf_data   (sf_data),
      .mask      (cfg_mask),
      .wide_word (wide_word),
      .narrow_smp(narrow_smp),
      .flags     (flags)
   );

   sfmt_packer #(
      .WORD_W  (WORD_W),
      .NARROW_W(NARROW_W),
      .RST_WIDE(RST_WIDE)
   ) u_pack (
      .clk           (clk),
      .rst_n         (rst_n),
      .sf_valid      (sf_valid),
      .sf_first      (sf_first),
      .sf_block_start(sf_block_start),
      .cfg_wide      (cfg_wide),
      .wide_word     (wide_word),
      .narrow_smp    (narrow_smp),
      .out_valid     (out_valid),
      .out_word      (out_word),
      .active_mode   (active_mode),
      .eff_wide      (eff_wide),
      .word_wide     (word_wide)
   );

   sfmt_status #(
      .FRAMES(FRAMES),
      .CS_W  (CS_W)
   ) u_sts (
      .clk           (clk),
      .rst_n         (rst_n),
      .sf_valid      (sf_valid),
      .sf_first      (sf_first),
      .sf_block_start(sf_block_start),
      .flags         (flags),
      .clr_parity    (clr_parity),
      .clr_invalid   (clr_invalid),
      .sts_parity_err(sts_parity_err),
      .sts_invalid   (sts_invalid),
      .cs_word       (cs_word)
   );
endmodule

// File: rtl/sfmt_formatter_chk.sv
module sfmt_formatter_chk
   import sfmt_pkg::*;
#(
   parameter int unsigned WORD_W = 32,
   parameter int unsigned AUD_W  = 24,
   parameter int unsigned CS_W   = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              sf_valid,
   input logic [SF_W-1:0]   sf_data,
   input logic              sf_first,
   input logic              sf_block_start,
   input logic              clr_parity,
   input logic              clr_invalid,
   input logic              out_valid,
   input logic [WORD_W-1:0] out_word,
   input logic              sts_parity_err,
   input logic              sts_invalid,
   input logic [CS_W-1:0]   cs_word,
   input sfmt_mode_e        active_mode,
   input logic              eff_wide,
   input logic              word_wide
);
   localparam int unsigned PAD_W = WORD_W - AUD_W;

   p_wide_strobe_r1: assert property (@(posedge clk) disable iff (!rst_n)
      sf_valid && eff_wide |=> out_valid);

   p_wide_pad_r1: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && word_wide |-> out_word[PAD_W-1:0] == '0);

   p_first_silent_r3: assert property (@(posedge clk) disable iff (!rst_n)
      sf_valid && !eff_wide && sf_first |=> !out_valid);

   p_no_spurious_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !sf_valid |=> !out_valid);

   p_mode_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !(sf_valid && sf_block_start) |=> $stable(active_mode));

   p_par_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
      sf_valid && (^sf_data[PAR_POS:AUD_LSB]) |=> sts_parity_err);

   p_par_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
      sts_parity_err && !clr_parity |=> sts_parity_err);

   p_par_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
      clr_parity && !(sf_valid && (^sf_data[PAR_POS:AUD_LSB])) |=> !sts_parity_err);

   p_inv_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
      sf_valid && sf_data[VALID_POS] |=> sts_invalid);

   p_inv_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
      sts_invalid && !clr_invalid |=> sts_invalid);

   p_cs_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !(sf_valid && sf_block_start) |=> $stable(cs_word));
endmodule

bind sfmt_formatter sfmt_formatter_chk #(
   .WORD_W(WORD_W),
   .AUD_W (AUD_W),
   .CS_W  (CS_W)
) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .sf_valid      (sf_valid),
   .sf_data       (sf_data),
   .sf_first      (sf_first),
   .sf_block_start(sf_block_start),
   .clr_parity    (clr_parity),
   .clr_invalid   (clr_invalid),
   .out_valid     (out_valid),
   .out_word      (out_word),
   .sts_parity_err(sts_parity_err),
   .sts_invalid   (sts_invalid),
   .cs_word       (cs_word),
   .active_mode   (active_mode),
   .eff_wide      (eff_wide),
   .word_wide     (word_wide)
);

// File: tb/sfmt_formatter_bench.sv
module sfmt_formatter_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sf_valid = 1'b0;
   logic [31:0] sf_data = '0;
   logic        sf_first = 1'b0;
   logic        sf_block_start = 1'b0;
   logic        cfg_wide = 1'b1;
   logic [23:0] cfg_mask = 24'hFFFFFF;
   logic        clr_parity = 1'b0;
   logic        clr_invalid = 1'b0;
   logic        out_valid;
   logic [31:0] out_word;
   logic        sts_parity_err;
   logic        sts_invalid;
   logic [31:0] cs_word;

   int unsigned checks = 0;
   int unsigned errors = 0;
   bit          done = 1'b0;

   // reference state
   bit          m_wide = 1'b1;
   bit          m_pend = 1'b0;
   logic [15:0] m_low = '0;
   bit          m_perr = 1'b0;
   bit          m_inv = 1'b0;
   logic [31:0] m_coll = '0;
   int          m_cnt = 0;
   logic [31:0] m_cs = '0;
   bit          last_ev = 1'b0;

   always #4 clk = ~clk;

   sfmt_formatter u_sfmt_formatter (
      .clk(clk), .rst_n(rst_n), .sf_valid(sf_valid), .sf_data(sf_data),
      .sf_first(sf_first), .sf_block_start(sf_block_start), .cfg_wide(cfg_wide),
      .cfg_mask(cfg_mask), .clr_parity(clr_parity), .clr_invalid(clr_invalid),
      .out_valid(out_valid), .out_word(out_word), .sts_parity_err(sts_parity_err),
      .sts_invalid(sts_invalid), .cs_word(cs_word)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] mk_sf(input logic [23:0] smp, input bit v,
                                         input bit cs, input bit bad_par);
      logic [31:0] d;
      d = {1'b0, cs, 1'b0, v, smp, 4'h0};
      d[31] = (^d[30:4]) ^ bad_par;
      return d;
   endfunction

   // drive one cycle of inputs, let the edge pass, compare against the model
   task automatic apply(input logic [31:0] d, input bit first, input bit bst,
                        input bit sv, input bit cp, input bit ci);
      bit          eff, ev;
      logic [31:0] ew;
      sf_valid = sv; sf_data = d; sf_first = first; sf_block_start = bst;
      clr_parity = cp; clr_invalid = ci;
      @(negedge clk);
      sf_valid = 0; sf_block_start = 0; clr_parity = 0; clr_invalid = 0;
      ev = 0; ew = '0;
      eff = (sv && bst) ? cfg_wide_at_drive : m_wide;
      if (sv && bst) begin m_wide = cfg_wide_at_drive; m_pend = 0; end
      if (sv) begin
         if (eff) begin
            ev = 1; ew = {d[27:4] & mask_at_drive, 8'h00};
         end else if (first) begin
            m_pend = 1; m_low = d[27:12];
         end else if (m_pend) begin
            ev = 1; ew = {d[27:12], m_low}; m_pend = 0;
         end
      end
      m_perr = (m_perr && !cp) || (sv && (^d[31:4]));
      m_inv  = (m_inv && !ci) || (sv && d[28]);
      if (sv && bst) begin m_cs = m_coll; m_coll = '0; m_cnt = 0; end
      if (sv && first) begin
         if (m_cnt < 32) m_coll[m_cnt] = d[30];
         if (m_cnt < 192) m_cnt++;
      end
      last_ev = ev;
      chk(eff ? "R1 out_valid" : "R3 out_valid", {31'd0, out_valid}, {31'd0, ev});
      if (ev) chk(eff ? "R1 out_word" : "R3 out_word", out_word, ew);
      chk(cp ? "R7 parity flag" : "R6 parity flag", {31'd0, sts_parity_err}, {31'd0, m_perr});
      chk(ci ? "R7 invalid flag" : "R8 invalid flag", {31'd0, sts_invalid}, {31'd0, m_inv});
      chk("R9 cs_word", cs_word, m_cs);
   endtask

   bit          cfg_wide_at_drive;
   logic [23:0] mask_at_drive;
   always_comb cfg_wide_at_drive = cfg_wide;
   always_comb mask_at_drive = cfg_mask;

   function automatic logic [23:0] pick_mask(input int unsigned r);
      case (r % 4)
         0: return 24'hFFFFFF;
         1: return 24'hFFFFF0;
         2: return 24'hFFFF00;
         default: return 24'hFFFFE0;
      endcase
   endfunction

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog expired");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      int unsigned seed;
      seed = $urandom(32'd6021);
      repeat (3) @(negedge clk);
      chk("R10 out_valid", {31'd0, out_valid}, 32'd0);
      chk("R10 parity flag", {31'd0, sts_parity_err}, 32'd0);
      chk("R10 invalid flag", {31'd0, sts_invalid}, 32'd0);
      chk("R10 cs_word", cs_word, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);

      // R10/R5: wide mode is active before any block start, whatever is requested
      cfg_wide = 1'b0;
      apply(mk_sf(24'h123456, 0, 0, 0), 1, 0, 1, 0, 0);
      chk("R5 wide at reset", {31'd0, last_ev}, 32'd1);

      // R2: truncating mask
      cfg_wide = 1'b1; cfg_mask = 24'hFFFFF0;
      apply(mk_sf(24'hABCDEF, 0, 1, 0), 1, 1, 1, 0, 0);
      chk("R2 masked word", out_word, 32'hABCDE000);

      // R4: narrow block, a pair then a lone second-channel subframe
      cfg_wide = 1'b0;
      apply(mk_sf(24'h111111, 0, 1, 0), 1, 1, 1, 0, 0);
      apply(mk_sf(24'h222222, 0, 0, 0), 0, 0, 1, 0, 0);
      chk("R3 pair word", out_word, 32'h22221111);
      apply(mk_sf(24'h333333, 0, 0, 0), 0, 0, 1, 0, 0);
      chk("R4 lone second no word", {31'd0, out_valid}, 32'd0);

      // R5: request wide mid-block, still narrow
      cfg_wide = 1'b1;
      apply(mk_sf(24'h444444, 0, 0, 0), 1, 0, 1, 0, 0);
      chk("R5 mid-block first silent", {31'd0, out_valid}, 32'd0);
      apply(mk_sf(24'h555555, 0, 0, 0), 0, 0, 1, 0, 0);
      chk("R5 mid-block still paired", out_word, 32'h55554444);

      // R7: fault with clear in the same cycle keeps flag; clear alone drops it
      apply(mk_sf(24'h000001, 1, 0, 1), 1, 0, 1, 1, 1);
      chk("R7 set wins parity", {31'd0, sts_parity_err}, 32'd1);
      chk("R7 set wins invalid", {31'd0, sts_invalid}, 32'd1);
      apply('0, 0, 0, 0, 0, 0);
      chk("R6 flag sticky", {31'd0, sts_parity_err}, 32'd1);
      apply('0, 0, 0, 0, 1, 1);
      chk("R7 cleared parity", {31'd0, sts_parity_err}, 32'd0);
      chk("R7 cleared invalid", {31'd0, sts_invalid}, 32'd0);

      // random blocks of 40 frames
      for (int blk = 0; blk < 14; blk++) begin
         cfg_wide = ($urandom % 2) == 1;
         cfg_mask = pick_mask($urandom);
         for (int fr = 0; fr < 40; fr++) begin
            for (int ch = 0; ch < 2; ch++) begin
               logic [23:0] smp;
               bit v, cs, bp, cp, ci;
               smp = 24'($urandom);
               v   = ($urandom % 16) == 0;
               cs  = ($urandom % 2) == 1;
               bp  = ($urandom % 20) == 0;
               cp  = ($urandom % 12) == 0;
               ci  = ($urandom % 12) == 0;
               if (fr == 17 && ch == 0) cfg_wide = ~cfg_wide;
               apply(mk_sf(smp, v, cs, bp), ch == 0, fr == 0 && ch == 0, 1, cp, ci);
               if (($urandom % 8) == 0) apply('0, 0, 0, 0, 0, 0);
            end
         end
      end
      // final block start publishes the last block
      apply(mk_sf(24'h0, 0, 0, 0), 1, 1, 1, 0, 0);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule